// File: doc/BRIEF.md
# Platform Reset Request Register

This block is a one-byte register on a simple I/O read/write bus. Software writes it to ask the platform to reset itself. The block watches every I/O access and responds to exactly one address. All other traffic passes it by untouched.

There are two kinds of write. A write with the trigger bit set makes the block emit a system reset request lasting one clock and leaves the stored byte alone. Any other write keeps only the reset-kind bit and clears the rest. A read returns the stored byte. The read data and the acknowledge are registered and appear in the cycle after the access. The reset request pulse is registered and appears in the same cycle as that acknowledge.

The block is a small leaf that sits next to a reset sequencer. The sequencer consumes the request pulse and may sample the stored reset-kind bit.

Top module: `sys_reset_ctl`

## Requirements
- R1: After reset the stored byte is 0x00. `sys_rst_req`, `io_ack` and `io_rdata` are all 0.
- R2: Only address 0x0CF9 (`REG_ADDR`) is decoded. An access at any other address gives no acknowledge, read data of 0 and no reset request, and leaves the stored byte unchanged.
- R3: A decoded write with bit 2 set drives `sys_rst_req` high for exactly one cycle, in the cycle after the write is sampled.
- R4: A decoded write with bit 2 set leaves the stored byte unchanged.
- R5: A decoded write with bit 2 clear stores bit 1 of the write data and stores 0 in every other bit.
- R6: A decoded write with bit 2 set raises the reset request whether bit 1 of the write data is 0 or 1.
- R7: A decoded read returns the stored byte on `io_rdata` in the cycle after it is sampled. At every other time `io_rdata` is 0.
- R8: Every decoded access (read or write) gets a one-cycle `io_ack` in the cycle after it is sampled. A cycle with both strobes high counts as a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, 0 unless answering a decoded read |
| io_ack | output | 1 | Registered acknowledge of a decoded access |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The in-line properties check the following on every cycle:
- every reset request pulse traces back to a decoded trigger write;
- a trigger write never changes the stored byte;
- a plain write stores the masked data;
- an acknowledge always follows a decoded access, and undecoded traffic never produces one.

Some behaviour only the directed scenarios show. These are the value a read returns after a particular history of writes, that the pulse falls after one cycle, and that bit 1 has no effect on triggering. They also cover the clearing of the stored byte by a reset in the middle of a run.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode
  import rstctl_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0CF9
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              addr_hit,
  output acc_kind_t         acc
);

  always_comb begin
    addr_hit = (io_addr == REG_ADDR);
    acc      = ACC_NONE;
    if (addr_hit) begin
      if (io_wr)      acc = ACC_WRITE;
      else if (io_rd) acc = ACC_READ;
    end
  end

endmodule

// File: rtl/rstctl_core.sv
module rstctl_core
  import rstctl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TRIG_BIT = 2,
  parameter int TYPE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_kind_t         acc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] store_q,
  output logic              req_q
);

  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << TYPE_BIT;

  logic is_write;
  logic is_trig;

  always_comb begin
    is_write = (acc == ACC_WRITE);
    is_trig  = is_write && wdata[TRIG_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= is_trig;
      if (is_write && !wdata[TRIG_BIT])
        store_q <= wdata & KEEP_MASK;
    end
  end

  // R3
  req_src_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(acc == ACC_WRITE && wdata[TRIG_BIT]));

  // R4
  trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_WRITE && wdata[TRIG_BIT]) |=> $stable(store_q));

  // R5
  plain_store_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_WRITE && !wdata[TRIG_BIT]) |=> (store_q == ($past(wdata) & KEEP_MASK)));

endmodule

// File: rtl/sys_reset_ctl.sv
module sys_reset_ctl
  import rstctl_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0CF9,
  parameter int                TRIG_BIT = 2,
  parameter int                TYPE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_ack,
  output logic              sys_rst_req
);

  acc_kind_t         acc;
  logic              addr_hit;
  logic [DATA_W-1:0] store_q;
  logic              req_q;
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q;

  rstctl_decode #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) decode_i (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .addr_hit(addr_hit),
    .acc     (acc)
  );

  rstctl_core #(
    .DATA_W  (DATA_W),
    .TRIG_BIT(TRIG_BIT),
    .TYPE_BIT(TYPE_BIT)
  ) core_i (
    .clk    (clk),
    .rst    (rst),
    .acc    (acc),
    .wdata  (io_wdata),
    .store_q(store_q),
    .req_q  (req_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= (acc != ACC_NONE);
      rdata_q <= (acc == ACC_READ) ? store_q : '0;
    end
  end

  assign io_ack      = ack_q;
  assign io_rdata    = rdata_q;
  assign sys_rst_req = req_q;

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((io_wr || io_rd) && !addr_hit) |=> (!io_ack && !sys_rst_req && io_rdata == '0));

  // R8
  ack_src_chk: assert property (@(posedge clk) disable iff (rst)
    io_ack |-> $past(addr_hit && (io_wr || io_rd)));

  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !io_ack |-> (io_rdata == '0));

  // R3
  req_has_ack_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> io_ack);

endmodule

// File: tb/sys_reset_ctl_tb_top.sv
module sys_reset_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_ack;
  logic        sys_rst_req;

  int total = 0;
  int bad   = 0;

  localparam logic [15:0] REG = 16'h0CF9;

  always #5 clk = ~clk;

  sys_reset_ctl dut_i (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .io_ack     (io_ack),
    .sys_rst_req(sys_rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one write: drive at negedge, sampled at posedge, results read at next negedge
  task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                          output logic ack, output logic req, output logic req_next);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    ack = io_ack; req = sys_rst_req;
    @(negedge clk);
    req_next = sys_rst_req;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d, output logic ack);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata; ack = io_ack;
  endtask

  task automatic t_reset_state();
    logic [7:0] d; logic a;
    check("R1 rst_req", sys_rst_req, 0);
    check("R1 ack", io_ack, 0);
    check("R1 rdata", io_rdata, 0);
    do_read(REG, d, a);
    check("R1 stored", d, 0);
  endtask

  task automatic t_plain_store();
    logic [7:0] d; logic a, r, rn;
    do_write(REG, 8'hFB, a, r, rn);
    check("R8 write ack", a, 1);
    check("R5 no pulse", r, 0);
    do_read(REG, d, a);
    check("R8 read ack", a, 1);
    check("R5 keep bit1 only (FB)", d, 8'h02);
    @(negedge clk);
    check("R7 rdata idle", io_rdata, 0);
    check("R8 ack one cycle", io_ack, 0);
    do_write(REG, 8'hF9, a, r, rn);
    do_read(REG, d, a);
    check("R5 bit1 clear (F9)", d, 8'h00);
  endtask

  task automatic t_trigger();
    logic [7:0] d; logic a, r, rn;
    do_write(REG, 8'h02, a, r, rn);
    do_write(REG, 8'h04, a, r, rn);
    check("R6 pulse with bit1=0", r, 1);
    check("R3 pulse ends", rn, 0);
    do_read(REG, d, a);
    check("R4 stored kept 02", d, 8'h02);
    do_write(REG, 8'h00, a, r, rn);
    do_write(REG, 8'hFF, a, r, rn);
    check("R6 pulse with bit1=1", r, 1);
    check("R3 pulse ends again", rn, 0);
    do_read(REG, d, a);
    check("R4 stored kept 00", d, 8'h00);
  endtask

  task automatic t_other_addr();
    logic [7:0] d; logic a, r, rn;
    do_write(16'h0CF8, 8'h02, a, r, rn);
    check("R2 no ack on miss write", a, 0);
    do_write(16'h0CFA, 8'h04, a, r, rn);
    check("R2 no pulse on miss", r, 0);
    check("R2 no ack on miss trigger", a, 0);
    do_write(16'h8CF9, 8'h06, a, r, rn);
    check("R2 no pulse high addr bit", r, 0);
    do_read(16'h0CF8, d, a);
    check("R2 miss read data", d, 0);
    check("R2 miss read ack", a, 0);
    do_read(REG, d, a);
    check("R2 stored untouched", d, 0);
  endtask

  task automatic t_both_strobes();
    logic [7:0] d; logic a;
    @(negedge clk);
    io_addr = REG; io_wdata = 8'h02; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    check("R8 both strobes ack", io_ack, 1);
    check("R8 both strobes no rdata", io_rdata, 0);
    do_read(REG, d, a);
    check("R8 both strobes wrote", d, 8'h02);
  endtask

  task automatic t_mid_reset();
    logic [7:0] d; logic a;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 req after reset", sys_rst_req, 0);
    do_read(REG, d, a);
    check("R1 cleared by reset", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_plain_store();
    t_trigger();
    t_other_addr();
    t_both_strobes();
    t_mid_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule